// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Model

This block is a synthesizable, cycle-accurate model of a synchronous SRAM whose bus never needs an idle cycle when it changes direction. On every enabled rising clock edge it samples an address, a read/write select, per-lane write strobes, three chip selects and a load/advance control. The data transfer for that command takes place two edges later, and reads and writes follow the same rule. A write captures the shared bidirectional bus on its second edge. A read drives the bus from its first edge onward, so the consumer can sample the word on the second edge. Because of this, a read may directly follow a write, or a write a read, on consecutive cycles.

The word is split into lanes, by default four lanes of nine bits: eight data bits and one parity bit. An active-low clock enable freezes the whole pipeline. An asynchronous output enable can silence the bus at any moment. Burst addresses come from an outside generator. In advance mode the block continues the operation type of the last load at whatever address is presented.

Top module: `zt_sram`

## Requirements
- R1: A read loaded at enabled edge k drives the stored word onto `dq` from edge k+1 until the next enabled edge, so it is valid at edge k+2. A write loaded at edge k stores the value present on `dq` at enabled edge k+2.
- R2: Reads and writes may alternate on consecutive cycles with no idle cycle. A read loaded one or two cycles after a write to the same address returns the newly written lanes.
- R3: While `cke_n` is 1, all synchronous inputs are ignored and all pipeline state, including the word on the bus, the pending transfers and the burst state, holds its value.
- R4: The device is selected only when `sel_a`=1, `sel_b`=1 and `sel_c_n`=0. A load (`adv_ld`=0) while unselected starts no operation and ends any burst. Transfers already loaded still complete.
- R5: With `adv_ld`=1 and a burst active, a new operation of the same type as the last load begins at `addr`, and `we_n` and the selects are ignored. With no burst active, advance does nothing.
- R6: `dq` is released (not driven by the block) from edge k+1 onward when the command at edge k was a write, a deselect or an idle advance.
- R7: `oe_n`=1 releases `dq` immediately and asynchronously, and it does not disturb the pipeline.
- R8: Lane i covers `dq[9i+8:9i]` (with the default lane width). Strobe `lane_we_n[i]`=0, sampled with the command, enables that lane to be written. Lanes whose strobe is 1 keep their old contents.
- R9: After reset, no operation is pending, no burst is active and `dq` is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of pipeline state |
| cke_n | input | 1 | Active-low clock enable; 1 freezes the block |
| adv_ld | input | 1 | 0 loads a new command, 1 advances the current burst |
| we_n | input | 1 | 0 selects write, 1 selects read (on load) |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| lane_we_n | input | LANES | Per-lane write strobes, active low |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq | inout | LANES*LANE_W | Shared data bus |

## Verification
The bench builds the block with a 4-bit address (16 words), four lanes and nine-bit lanes. With so few words, random traffic hits the same address in back-to-back and one-apart pairs many times. This exercises the same-edge forwarding path from a committing write into a following read, and every word can be preloaded directly so that each read has a known expected value. The four lanes of nine bits keep the parity position inside each lane, so partial-strobe writes show that a neighbouring lane is left untouched.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

   // operation carried through the two pipeline stages
   typedef enum logic [1:0] {
      ZT_IDLE  = 2'd0,
      ZT_READ  = 2'd1,
      ZT_WRITE = 2'd2
   } zt_op_e;

   // bounds checked at elaboration by the top module
   localparam int ZT_MAX_ADDR_W = 12;
   localparam int ZT_MAX_LANES  = 8;
   localparam int ZT_MAX_LANE_W = 16;

endpackage

// File: rtl/zt_cmd_stage.sv
module zt_cmd_stage
   import zt_sram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke_n,
   input  logic              adv_ld,
   input  logic              we_n,
   input  logic              sel_a,
   input  logic              sel_b,
   input  logic              sel_c_n,
   input  logic [LANES-1:0]  lane_we_n,
   input  logic [ADDR_W-1:0] addr_i,
   output zt_op_e            p1_op,
   output logic [ADDR_W-1:0] p1_addr,
   output zt_op_e            p2_op,
   output logic [ADDR_W-1:0] p2_addr,
   output logic [LANES-1:0]  p2_lanes,
   output logic              burst_q
);

   logic             sel_on;
   logic             burst_d;
   zt_op_e           op_d;
   zt_op_e           burst_op_q;
   zt_op_e           burst_op_d;
   logic [LANES-1:0] p1_lanes;

   // decode of the command presented this cycle
   always_comb begin
      sel_on     = sel_a & sel_b & ~sel_c_n;
      op_d       = ZT_IDLE;
      burst_d    = burst_q;
      burst_op_d = burst_op_q;
      if (!adv_ld) begin
         if (sel_on) begin
            op_d       = we_n ? ZT_READ : ZT_WRITE;
            burst_d    = 1'b1;
            burst_op_d = op_d;
         end else begin
            burst_d    = 1'b0;
         end
      end else if (burst_q) begin
         op_d = burst_op_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p1_op      <= ZT_IDLE;
         p1_addr    <= '0;
         p1_lanes   <= '0;
         p2_op      <= ZT_IDLE;
         p2_addr    <= '0;
         p2_lanes   <= '0;
         burst_q    <= 1'b0;
         burst_op_q <= ZT_IDLE;
      end else if (!cke_n) begin
         p1_op      <= op_d;
         p1_addr    <= addr_i;
         p1_lanes   <= ~lane_we_n;
         p2_op      <= p1_op;
         p2_addr    <= p1_addr;
         p2_lanes   <= p1_lanes;
         burst_q    <= burst_d;
         burst_op_q <= burst_op_d;
      end
   end

endmodule

// File: rtl/zt_lane_array.sv
module zt_lane_array #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int DEPTH = 1 << ADDR_W,
   localparam int WORD_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [LANES-1:0]  wr_lanes,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_word
);

   logic addr_hit;
   assign addr_hit = wr_en && (wr_addr == rd_addr);

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];
      logic [LANE_W-1:0] lane_rd;

      always_ff @(posedge clk) begin
         if (wr_en && wr_lanes[ln]) begin
            cells[wr_addr] <= wr_word[ln*LANE_W +: LANE_W];
         end
      end

      // a write committing on the same edge forwards its lane to the read
      always_comb begin
         if (addr_hit && wr_lanes[ln]) begin
            lane_rd = wr_word[ln*LANE_W +: LANE_W];
         end else begin
            lane_rd = cells[rd_addr];
         end
      end

      assign rd_word[ln*LANE_W +: LANE_W] = lane_rd;
   end

endmodule

// File: rtl/zt_out_stage.sv
module zt_out_stage #(
   parameter int WORD_W         = 36,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke_n,
   input  logic              take_rd,
   input  logic [WORD_W-1:0] rd_word,
   output logic              drv_q,
   output logic [WORD_W-1:0] dout_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_q <= 1'b0;
      end else if (!cke_n) begin
         drv_q <= take_rd;
      end
   end

   if (CLEAR_ON_RESET) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dout_q <= '0;
         end else if (!cke_n && take_rd) begin
            dout_q <= rd_word;
         end
      end
   end else begin : g_noclr
      always_ff @(posedge clk) begin
         if (!cke_n && take_rd) begin
            dout_q <= rd_word;
         end
      end
   end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
   import zt_sram_pkg::*;
#(
   parameter int ADDR_W         = 8,
   parameter int LANES          = 4,
   parameter int LANE_W         = 9,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int DW            = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke_n,
   input  logic              adv_ld,
   input  logic              we_n,
   input  logic              sel_a,
   input  logic              sel_b,
   input  logic              sel_c_n,
   input  logic [LANES-1:0]  lane_we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              oe_n,
   inout  wire  [DW-1:0]     dq
);

   if (ADDR_W < 2 || ADDR_W > ZT_MAX_ADDR_W) begin : g_bad_addr
      $error("zt_sram: ADDR_W out of range");
   end
   if (LANES < 1 || LANES > ZT_MAX_LANES) begin : g_bad_lanes
      $error("zt_sram: LANES out of range");
   end
   if (LANE_W < 1 || LANE_W > ZT_MAX_LANE_W) begin : g_bad_lane_w
      $error("zt_sram: LANE_W out of range");
   end

   zt_op_e            p1_op;
   zt_op_e            p2_op;
   logic [ADDR_W-1:0] p1_addr;
   logic [ADDR_W-1:0] p2_addr;
   logic [LANES-1:0]  p2_lanes;
   logic              burst_q;
   logic              wr_en;
   logic              take_rd;
   logic [DW-1:0]     rd_word;
   logic [DW-1:0]     dout_q;
   logic              drv_q;

   zt_cmd_stage #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES)
   ) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .cke_n     (cke_n),
      .adv_ld    (adv_ld),
      .we_n      (we_n),
      .sel_a     (sel_a),
      .sel_b     (sel_b),
      .sel_c_n   (sel_c_n),
      .lane_we_n (lane_we_n),
      .addr_i    (addr),
      .p1_op     (p1_op),
      .p1_addr   (p1_addr),
      .p2_op     (p2_op),
      .p2_addr   (p2_addr),
      .p2_lanes  (p2_lanes),
      .burst_q   (burst_q)
   );

   assign wr_en   = !cke_n && (p2_op == ZT_WRITE);
   assign take_rd = (p1_op == ZT_READ);

   zt_lane_array #(
      .ADDR_W (ADDR_W),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_array (
      .clk      (clk),
      .wr_en    (wr_en),
      .wr_addr  (p2_addr),
      .wr_lanes (p2_lanes),
      .wr_word  (dq),
      .rd_addr  (p1_addr),
      .rd_word  (rd_word)
   );

   zt_out_stage #(
      .WORD_W         (DW),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .cke_n   (cke_n),
      .take_rd (take_rd),
      .rd_word (rd_word),
      .drv_q   (drv_q),
      .dout_q  (dout_q)
   );

   assign dq = (drv_q && !oe_n) ? dout_q : {DW{1'bz}};

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
   parameter int DW = 36
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cke_n,
   input logic          adv_ld,
   input logic          we_n,
   input logic          sel_a,
   input logic          sel_b,
   input logic          sel_c_n,
   input logic          drv_q,
   input logic          burst_q,
   input logic [DW-1:0] dout_q
);

   logic sel_on;
   assign sel_on = sel_a & sel_b & ~sel_c_n;

   // R1
   read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !adv_ld && sel_on && we_n) ##1 !cke_n |=> drv_q);

   // R6
   write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !adv_ld && sel_on && !we_n) ##1 !cke_n |=> !drv_q);

   // R4
   deselect_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !adv_ld && !sel_on) ##1 !cke_n |=> !drv_q);

   // R5
   idle_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && adv_ld && !burst_q) ##1 !cke_n |=> !drv_q);

   // R3
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cke_n |=> ($stable(drv_q) && $stable(dout_q) && $stable(burst_q)));

   // R9
   reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!drv_q && !burst_q));

endmodule

bind zt_sram zt_sram_chk #(.DW(DW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cke_n   (cke_n),
   .adv_ld  (adv_ld),
   .we_n    (we_n),
   .sel_a   (sel_a),
   .sel_b   (sel_b),
   .sel_c_n (sel_c_n),
   .drv_q   (drv_q),
   .burst_q (burst_q),
   .dout_q  (dout_q)
);

// File: tb/sim_zt_sram.sv
module sim_zt_sram;

   localparam int AW = 4;
   localparam int LN = 4;
   localparam int LW = 9;
   localparam int DW = LN * LW;

   typedef enum int {B_IDLE, B_RD, B_WR} bop_e;
   typedef struct {
      bop_e          op;
      logic [AW-1:0] a;
      logic [LN-1:0] ln;
      logic [DW-1:0] d;
      string         tag;
   } bent_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cke_n = 1'b1;
   logic          adv_ld = 1'b0;
   logic          we_n = 1'b1;
   logic          sel_a = 1'b0;
   logic          sel_b = 1'b0;
   logic          sel_c_n = 1'b1;
   logic          oe_n = 1'b0;
   logic [LN-1:0] lane_we_n = '1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] tb_dq = '0;
   logic          tb_dq_en = 1'b0;
   wire  [DW-1:0] dq;

   assign dq = tb_dq_en ? tb_dq : {DW{1'bz}};
   for (genvar g = 0; g < DW; g++) begin : g_pu
      pullup (dq[g]);
   end

   always #5 clk = ~clk;

   zt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .cke_n     (cke_n),
      .adv_ld    (adv_ld),
      .we_n      (we_n),
      .sel_a     (sel_a),
      .sel_b     (sel_b),
      .sel_c_n   (sel_c_n),
      .lane_we_n (lane_we_n),
      .addr      (addr),
      .oe_n      (oe_n),
      .dq        (dq)
   );

   int            vecs = 0;
   int            fails = 0;
   bit            done = 1'b0;
   logic [DW-1:0] bmem [1 << AW];
   bent_t         bp1;
   bent_t         bp2;
   logic          bout_en = 1'b0;
   logic [DW-1:0] bout = '0;
   string         bout_tag = "";
   bit            bb_on = 1'b0;
   bop_e          bb_op = B_IDLE;
   string         tag_ovr = "";

   function automatic logic [DW-1:0] rnd_word();
      logic [63:0] r;
      r = {$urandom(), $urandom()};
      if (r[DW-1:0] == {DW{1'b1}}) r[0] = 1'b0;
      return r[DW-1:0];
   endfunction

   // R8: lane i occupies bits [i*LW +: LW]
   function automatic logic [DW-1:0] merge_lanes(input logic [DW-1:0] old_w,
                                                 input logic [DW-1:0] new_w,
                                                 input logic [LN-1:0] en);
      logic [DW-1:0] res;
      res = old_w;
      for (int i = 0; i < LN; i++) begin
         if (en[i]) res[i*LW +: LW] = new_w[i*LW +: LW];
      end
      return res;
   endfunction

   function automatic logic [DW-1:0] exp_bus();
      // released bus reads as the pull-up pattern
      return (bout_en && !oe_n) ? bout : {DW{1'b1}};
   endfunction

   task automatic check_bus();
      logic [DW-1:0] e;
      string t;
      e = exp_bus();
      if (tag_ovr != "") t = tag_ovr;
      else if (bout_en) t = oe_n ? "R7" : bout_tag;
      else t = "R6";
      vecs++;
      if (dq !== e) begin
         fails++;
         $display("FAIL %s: dq=%h expected %h at %0t", t, dq, e, $time);
      end
   endtask

   task automatic model_edge(input logic adv, input logic we, input logic sa,
                             input logic sb, input logic scn,
                             input logic [LN-1:0] bw_n, input logic [AW-1:0] a,
                             input string tag);
      bent_t nx;
      logic  on;
      if (bp2.op == B_WR) bmem[bp2.a] = merge_lanes(bmem[bp2.a], bp2.d, bp2.ln);
      bout_en = (bp1.op == B_RD);
      if (bp1.op == B_RD) begin
         bout     = bmem[bp1.a];
         bout_tag = bp1.tag;
      end
      on = sa & sb & ~scn;
      nx.op = B_IDLE;
      if (!adv) begin
         if (on) begin
            nx.op = we ? B_RD : B_WR;
            bb_on = 1'b1;
            bb_op = nx.op;
         end else begin
            bb_on = 1'b0;
         end
      end else if (bb_on) begin
         nx.op = bb_op;
      end
      nx.a   = a;
      nx.ln  = ~bw_n;
      nx.d   = rnd_word();
      nx.tag = tag;
      bp2 = bp1;
      bp1 = nx;
   endtask

   task automatic cyc(input logic ck_n, input logic adv, input logic we,
                      input logic sa, input logic sb, input logic scn,
                      input logic [LN-1:0] bw_n, input logic [AW-1:0] a,
                      input logic oe, input string tag);
      @(negedge clk);
      oe_n = oe;
      #1;
      check_bus();
      cke_n     = ck_n;
      adv_ld    = adv;
      we_n      = we;
      sel_a     = sa;
      sel_b     = sb;
      sel_c_n   = scn;
      lane_we_n = bw_n;
      addr      = a;
      if (bp2.op == B_WR) begin
         tb_dq    = bp2.d;
         tb_dq_en = 1'b1;
      end
      @(posedge clk);
      if (!ck_n) model_edge(adv, we, sa, sb, scn, bw_n, a, tag);
      #1;
      tb_dq_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, input string tag);
      cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, '1, a, 1'b0, tag);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [LN-1:0] bw_n, input string tag);
      cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, bw_n, a, 1'b0, tag);
   endtask

   task automatic idle(input string tag);
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '1, '0, 1'b0, tag);
   endtask

   // advance: select and direction inputs deliberately set to "off/other"
   task automatic adv_step(input logic [AW-1:0] a, input logic we,
                           input logic [LN-1:0] bw_n, input string tag);
      cyc(1'b0, 1'b1, we, 1'b0, 1'b0, 1'b1, bw_n, a, 1'b0, tag);
   endtask

   task automatic stall(input string tag);
      cyc(1'b1, 1'($urandom_range(1)), 1'($urandom_range(1)), 1'b1, 1'b1, 1'b0,
          4'($urandom()), 4'($urandom()), 1'b0, tag);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5A17));
      bp1 = '{op: B_IDLE, a: '0, ln: '0, d: '0, tag: ""};
      bp2 = bp1;

      // R9: bus released during and just after reset
      tag_ovr = "R9";
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         #1;
         check_bus();
      end
      @(negedge clk);
      rst_n = 1'b1;
      idle("R9");
      idle("R9");
      idle("R9");
      tag_ovr = "";

      // R1: preload every word back to back, then read back
      for (int i = 0; i < (1 << AW); i++) wr(AW'(i), '0, "R1");
      for (int i = 0; i < (1 << AW); i++) rd(AW'(i), "R1");
      idle("R6");
      idle("R6");

      // R2: alternation without idle, read one and two after a write
      wr(4'd3, '0, "R2");
      rd(4'd3, "R2");
      rd(4'd3, "R2");
      wr(4'd5, '0, "R2");
      rd(4'd2, "R2");
      wr(4'd2, '0, "R2");
      rd(4'd5, "R2");
      rd(4'd2, "R2");
      idle("R6");

      // R8: partial strobes (lanes 0 and 2 written, 1 and 3 kept)
      wr(4'd7, 4'b1010, "R8");
      rd(4'd7, "R8");
      wr(4'd7, 4'b0111, "R8");
      rd(4'd7, "R8");
      idle("R8");
      idle("R8");

      // R3: stall with junk inputs, read data and pending write held
      rd(4'd1, "R3");
      stall("R3");
      stall("R3");
      stall("R3");
      wr(4'd9, '0, "R3");
      stall("R3");
      stall("R3");
      rd(4'd9, "R3");
      idle("R3");
      idle("R3");

      // R4: deselect load ends nothing in flight, starts nothing new
      rd(4'd4, "R4");
      cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '1, 4'd6, 1'b0, "R4");
      cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '1, 4'd6, 1'b0, "R4");
      wr(4'd8, '0, "R4");
      idle("R4");
      rd(4'd8, "R4");
      idle("R4");
      idle("R4");

      // R5: advance continues type, ignores selects and we_n; no burst -> nothing
      rd(4'd10, "R5");
      adv_step(4'd11, 1'b0, '1, "R5");
      adv_step(4'd12, 1'b0, '1, "R5");
      wr(4'd13, '0, "R5");
      adv_step(4'd14, 1'b1, 4'b1100, "R5");
      idle("R5");
      adv_step(4'd13, 1'b1, '1, "R5");
      adv_step(4'd14, 1'b0, '1, "R5");
      rd(4'd13, "R5");
      rd(4'd14, "R5");
      idle("R5");
      idle("R5");

      // R7: output enable silences bus asynchronously, pipeline unaffected
      rd(4'd0, "R7");
      rd(4'd1, "R7");
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '1, '0, 1'b1, "R7");
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '1, '0, 1'b0, "R7");
      idle("R7");

      // R2: constrained random traffic on a small address window
      for (int n = 0; n < 3000; n++) begin
         logic ck, ad, we, sa, sb, sc, oe;
         ck = ($urandom_range(9) == 0);
         ad = ($urandom_range(9) < 3);
         we = $urandom_range(1);
         if ($urandom_range(9) < 8) begin
            sa = 1'b1; sb = 1'b1; sc = 1'b0;
         end else begin
            sa = $urandom_range(1); sb = $urandom_range(1); sc = $urandom_range(1);
         end
         oe = ($urandom_range(19) == 0);
         cyc(ck, ad, we, sa, sb, sc, 4'($urandom()), 4'($urandom()), oe, "R2");
      end
      idle("R6");
      idle("R6");
      idle("R6");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
   end

endmodule